// File: doc/BRIEF.md
# Flash Chip-Select Window Decoder

This block maps a flat bus address space onto up to three serial flash devices. Each chip select owns one segment register, which holds the first and the one-past-last address of its window in coarse 8 MB units. Every bus access is compared against all windows at once. One registered cycle later the block reports which chip select was hit and the byte offset of the access inside that window. If no window is hit, it raises a miss flag instead.

Software normally programs the windows in increasing chip-select order, with each window starting where the previous one ends. This gives one contiguous region across all attached devices. The decoder does not depend on that layout. It tolerates overlapping windows by letting the lowest index win, and it never lets a window reach past the end of the controller's mapped region. A small register port gives read and write access to the segment registers. Protocol conversion, serial shifting and flash command sequencing happen elsewhere.

Top module: `fcs_window_decoder`

## Requirements
- R1: After reset every segment register reads as zero, so every window is closed, and `hit_valid`, `hit_sel`, `hit_offset` and `miss_err` are all low.
- R2: The segment register of chip select i sits at configuration offset 0x30 + 4*i. Bits 31:24 hold the window end and bits 23:16 hold the window start, each in 8 MB units. A write stores only those two fields, and bits 15:0 always read as zero.
- R3: A write to any configuration offset that is not a segment register changes no register, and such an offset reads as zero.
- R4: A window whose start field is greater than or equal to its end field is closed and never matches.
- R5: An access matches chip select i when start*8MB <= address < end*8MB. The end is exclusive. The result appears on the outputs on the clock edge after the one that samples `acc_valid`.
- R6: When several windows contain the address, only the lowest chip-select index is reported, so `hit_sel` is never more than one-hot.
- R7: On a hit, `hit_offset` equals the bus address minus start*8MB.
- R8: An access that matches no window produces `hit_valid` and `miss_err` high, with `hit_sel` and `hit_offset` zero.
- R9: An address at or above the top of the mapped region (REGION_HI_U units, 32 = 256 MB by default) never matches. A window end beyond that top is treated as that top.
- R10: A cycle without `acc_valid` produces all-zero outputs on the next cycle.
- R11: A decode uses the segment values held before a register write in the same cycle. The write takes effect from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` (combinational) |
| acc_valid | input | 1 | Bus access present |
| acc_addr | input | 32 | Bus byte address |
| hit_valid | output | 1 | Decode result present |
| hit_sel | output | 3 | One-hot matched chip select |
| hit_offset | output | 32 | Byte offset inside the matched window |
| miss_err | output | 1 | Access matched no window |

## Verification
The assertions check on every cycle the properties that hold whatever the registers contain:
- the one-cycle latency and the all-zero idle result;
- the one-hot chip select;
- the exclusive relation between a match and the miss flag;
- zero low bits on read data;
- the forced miss above the top of the mapped region.

Only the bench's scenarios can show the properties that depend on programmed contents:
- end exclusivity at window boundaries;
- closed windows, including start equal to end;
- lowest-index priority under overlap;
- exact offsets;
- ignored writes to other offsets;
- the ordering of a same-cycle write and decode.

The bench compares these against a behavioural model on every clock.

// File: rtl/fcs_win_pkg.sv
package fcs_win_pkg;

  localparam int UNIT_W = 8;
  localparam int CFG_AW = 8;
  localparam int CFG_DW = 32;
  localparam logic [CFG_AW-1:0] SEG_BASE_OFS = 8'h30;

  typedef struct packed {
    logic [UNIT_W-1:0] end_u;
    logic [UNIT_W-1:0] start_u;
  } seg_t;

  function automatic logic [CFG_AW-1:0] seg_offset(input int idx);
    return SEG_BASE_OFS + CFG_AW'(4 * idx);
  endfunction

endpackage

// File: rtl/fcs_seg_regs.sv
module fcs_seg_regs
  import fcs_win_pkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [CFG_DW-1:0]          cfg_wdata,
  output logic [CFG_DW-1:0]          cfg_rdata,
  output seg_t [NUM_CS-1:0]          segs
);

  localparam int LOW_W = CFG_DW - 2 * UNIT_W;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_seg
    logic wr_en;
    seg_t seg_d;
    seg_t seg_q;

    always_comb begin
      wr_en         = cfg_we && (cfg_addr == seg_offset(g));
      seg_d.end_u   = cfg_wdata[CFG_DW-1 -: UNIT_W];
      seg_d.start_u = cfg_wdata[CFG_DW-1-UNIT_W -: UNIT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q <= '0;
      end else if (wr_en) begin
        seg_q <= seg_d;
      end
    end

    assign segs[g] = seg_q;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (cfg_addr == seg_offset(i)) begin
        cfg_rdata = {segs[i].end_u, segs[i].start_u, {LOW_W{1'b0}}};
      end
    end
  end

endmodule

// File: rtl/fcs_win_match.sv
module fcs_win_match
  import fcs_win_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int UNIT_SHIFT  = 23,
  parameter int REGION_LO_U = 0,
  parameter int REGION_HI_U = 32
) (
  input  seg_t              seg,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);

  localparam int UA_W = ADDR_W - UNIT_SHIFT;
  localparam logic [UA_W-1:0] LO_U = UA_W'(REGION_LO_U);
  localparam logic [UA_W-1:0] HI_U = UA_W'(REGION_HI_U);

  logic [UA_W-1:0] ua;
  logic [UA_W-1:0] start_x;
  logic [UA_W-1:0] end_x;
  logic [UA_W-1:0] end_eff;
  logic            win_open;
  logic            in_win;
  logic            in_region;

  always_comb begin
    ua        = acc_addr[ADDR_W-1:UNIT_SHIFT];
    start_x   = UA_W'(seg.start_u);
    end_x     = UA_W'(seg.end_u);
    end_eff   = (end_x > HI_U) ? HI_U : end_x;
    win_open  = seg.start_u < seg.end_u;
    in_win    = (ua >= start_x) && (ua < end_eff);
    in_region = (ua >= LO_U) && (ua < HI_U);
    hit       = win_open && in_win && in_region;
    offset    = acc_addr - (ADDR_W'(seg.start_u) << UNIT_SHIFT);
  end

endmodule

// File: rtl/fcs_win_arb.sv
module fcs_win_arb #(
  parameter int NUM_CS = 3,
  parameter int ADDR_W = 32
) (
  input  logic [NUM_CS-1:0]        hits,
  input  logic [NUM_CS*ADDR_W-1:0] offs,
  output logic [NUM_CS-1:0]        sel,
  output logic [ADDR_W-1:0]        offset,
  output logic                     any_hit
);

  always_comb begin
    sel     = '0;
    offset  = '0;
    any_hit = |hits;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        offset = offs[i*ADDR_W +: ADDR_W];
      end
    end
  end

endmodule

// File: rtl/fcs_window_decoder.sv
module fcs_window_decoder
  import fcs_win_pkg::*;
#(
  parameter int NUM_CS      = 3,
  parameter int ADDR_W      = 32,
  parameter int UNIT_SHIFT  = 23,
  parameter int REGION_LO_U = 0,
  parameter int REGION_HI_U = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              hit_valid,
  output logic [NUM_CS-1:0] hit_sel,
  output logic [ADDR_W-1:0] hit_offset,
  output logic              miss_err
);

  seg_t [NUM_CS-1:0]        segs;
  logic [NUM_CS-1:0]        hits;
  logic [NUM_CS*ADDR_W-1:0] offs;
  logic [NUM_CS-1:0]        pick_sel;
  logic [ADDR_W-1:0]        pick_off;
  logic                     any_hit;

  logic              valid_d;
  logic [NUM_CS-1:0] sel_d;
  logic [ADDR_W-1:0] off_d;
  logic              err_d;
  logic              out_en;

  fcs_seg_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .segs      (segs)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_match
    fcs_win_match #(
      .ADDR_W      (ADDR_W),
      .UNIT_SHIFT  (UNIT_SHIFT),
      .REGION_LO_U (REGION_LO_U),
      .REGION_HI_U (REGION_HI_U)
    ) u_match (
      .seg      (segs[g]),
      .acc_addr (acc_addr),
      .hit      (hits[g]),
      .offset   (offs[g*ADDR_W +: ADDR_W])
    );
  end

  fcs_win_arb #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_arb (
    .hits    (hits),
    .offs    (offs),
    .sel     (pick_sel),
    .offset  (pick_off),
    .any_hit (any_hit)
  );

  always_comb begin
    out_en  = acc_valid || hit_valid;
    valid_d = acc_valid;
    sel_d   = acc_valid ? pick_sel : '0;
    off_d   = (acc_valid && any_hit) ? pick_off : '0;
    err_d   = acc_valid && !any_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid  <= 1'b0;
      hit_sel    <= '0;
      hit_offset <= '0;
      miss_err   <= 1'b0;
    end else if (out_en) begin
      hit_valid  <= valid_d;
      hit_sel    <= sel_d;
      hit_offset <= off_d;
      miss_err   <= err_d;
    end
  end

endmodule

// File: rtl/fcs_window_decoder_chk.sv
module fcs_window_decoder_chk #(
  parameter int NUM_CS      = 3,
  parameter int ADDR_W      = 32,
  parameter int UNIT_SHIFT  = 23,
  parameter int REGION_HI_U = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg_rdata,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              hit_valid,
  input logic [NUM_CS-1:0] hit_sel,
  input logic [ADDR_W-1:0] hit_offset,
  input logic              miss_err
);

  localparam int UA_W = ADDR_W - UNIT_SHIFT;
  localparam logic [UA_W-1:0] HI_U = UA_W'(REGION_HI_U);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_sel)); // R6

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> hit_valid); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!hit_valid && hit_sel == '0 && hit_offset == '0 && !miss_err)); // R10

  AST_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err |-> (hit_valid && hit_sel == '0 && hit_offset == '0)); // R8

  AST_RESULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (($countones(hit_sel) == 1) != miss_err)); // R8

  AST_RDATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[15:0] == 16'h0); // R2

  AST_ABOVE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[ADDR_W-1:UNIT_SHIFT] >= HI_U) |=> miss_err); // R9

endmodule

bind fcs_window_decoder fcs_window_decoder_chk #(
  .NUM_CS      (NUM_CS),
  .ADDR_W      (ADDR_W),
  .UNIT_SHIFT  (UNIT_SHIFT),
  .REGION_HI_U (REGION_HI_U)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_rdata  (cfg_rdata),
  .acc_valid  (acc_valid),
  .acc_addr   (acc_addr),
  .hit_valid  (hit_valid),
  .hit_sel    (hit_sel),
  .hit_offset (hit_offset),
  .miss_err   (miss_err)
);

// File: tb/fcs_window_decoder_bench.sv
`timescale 1ns/1ps
module fcs_window_decoder_bench;

  localparam int NCS = 3;
  localparam int TOP_U = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic        hit_valid;
  logic [2:0]  hit_sel;
  logic [31:0] hit_offset;
  logic        miss_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  int m_start [NCS];
  int m_end   [NCS];

  logic        e_valid;
  logic [2:0]  e_sel;
  logic [31:0] e_off;
  logic        e_err;

  always #2.5 clk = ~clk;

  fcs_window_decoder u_fcs_window_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .hit_valid  (hit_valid),
    .hit_sel    (hit_sel),
    .hit_offset (hit_offset),
    .miss_err   (miss_err)
  );

  function automatic logic [31:0] model_read(input logic [7:0] a);
    for (int i = 0; i < NCS; i++)
      if (a == 8'h30 + 8'(4 * i))
        return {8'(m_end[i]), 8'(m_start[i]), 16'h0};
    return 32'h0;
  endfunction

  task automatic model_decode(input bit av, input logic [31:0] aa);
    int ua;
    int lim;
    e_valid = av;
    e_sel = 3'b000;
    e_off = 32'h0;
    e_err = 1'b0;
    if (av) begin
      ua = int'(aa >> 23);
      for (int i = 0; i < NCS; i++) begin
        lim = (m_end[i] > TOP_U) ? TOP_U : m_end[i];
        if (e_sel == 3'b000 && m_start[i] < m_end[i] &&
            ua >= m_start[i] && ua < lim && ua < TOP_U) begin
          e_sel = 3'(1 << i);
          e_off = aa - (32'(m_start[i]) << 23);
        end
      end
      e_err = (e_sel == 3'b000);
    end
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge, update the model at the
  // rising edge, compare at the next falling edge.
  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] wd,
                      input bit av, input logic [31:0] aa, input string tag);
    logic [31:0] e_rd;
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    acc_valid = av; acc_addr = aa;
    @(posedge clk);
    model_decode(av, aa);
    if (we)
      for (int i = 0; i < NCS; i++)
        if (a == 8'h30 + 8'(4 * i)) begin
          m_end[i] = int'(wd[31:24]);
          m_start[i] = int'(wd[23:16]);
        end
    @(negedge clk);
    e_rd = model_read(a);
    vectors++;
    cmp(tag, "hit_valid", 32'(hit_valid), 32'(e_valid));
    cmp(tag, "hit_sel", 32'(hit_sel), 32'(e_sel));
    cmp(tag, "hit_offset", hit_offset, e_off);
    cmp(tag, "miss_err", 32'(miss_err), 32'(e_err));
    cmp(tag, "cfg_rdata", cfg_rdata, e_rd);
  endtask

  task automatic wr_seg(input int cs, input int st, input int en, input string tag);
    step(1'b1, 8'h30 + 8'(4 * cs), {8'(en), 8'(st), 16'hBEEF}, 1'b0, 32'h0, tag);
  endtask

  task automatic acc(input logic [31:0] aa, input string tag);
    step(1'b0, 8'h30, 32'h0, 1'b1, aa, tag);
  endtask

  initial begin
    for (int i = 0; i < NCS; i++) begin m_start[i] = 0; m_end[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents and outputs
    step(1'b0, 8'h30, 32'h0, 1'b0, 32'h0, "R1");
    step(1'b0, 8'h34, 32'h0, 1'b0, 32'h0, "R1");
    step(1'b0, 8'h38, 32'h0, 1'b0, 32'h0, "R1");
    acc(32'h0000_0000, "R1");

    // R2: contiguous layout, low bits dropped
    wr_seg(0, 0, 4, "R2");
    wr_seg(1, 4, 6, "R2");
    wr_seg(2, 6, 40, "R2");
    step(1'b0, 8'h34, 32'h0, 1'b0, 32'h0, "R2");

    // R5 / R7: boundaries and offsets
    acc(32'h0000_0000, "R5");
    acc(32'h01FF_FFFF, "R5");
    acc(32'h0200_0000, "R5");
    acc(32'h02FF_FFFC, "R7");
    acc(32'h0300_0000, "R7");
    acc(32'h0ABC_DEF1, "R7");

    // R9: region top clamps a window reaching past it
    acc(32'h0FFF_FFFF, "R9");
    acc(32'h1000_0000, "R9");
    acc(32'h1400_0000, "R9");
    acc(32'hFFFF_FFFF, "R9");

    // R3: writes to other offsets ignored
    step(1'b1, 8'h40, 32'hFFFF_FFFF, 1'b0, 32'h0, "R3");
    step(1'b1, 8'h31, 32'h0000_0000, 1'b0, 32'h0, "R3");
    step(1'b1, 8'h2C, 32'h0000_0000, 1'b0, 32'h0, "R3");
    step(1'b0, 8'h40, 32'h0, 1'b0, 32'h0, "R3");
    step(1'b0, 8'h30, 32'h0, 1'b0, 32'h0, "R3");
    acc(32'h0100_0000, "R3");

    // R4: closed windows
    wr_seg(1, 5, 5, "R4");
    acc(32'h0280_0000, "R4");
    wr_seg(1, 6, 4, "R4");
    acc(32'h0200_0000, "R4");
    acc(32'h0280_0000, "R4");

    // R6: overlap, lowest index wins
    wr_seg(0, 0, 8, "R6");
    wr_seg(1, 2, 6, "R6");
    wr_seg(2, 3, 10, "R6");
    acc(32'h0180_0000, "R6");
    acc(32'h0400_0010, "R6");
    acc(32'h04FF_FFFF, "R6");

    // R8: miss
    wr_seg(0, 10, 12, "R8");
    wr_seg(1, 0, 0, "R8");
    wr_seg(2, 14, 16, "R8");
    acc(32'h0000_1000, "R8");
    acc(32'h0600_0000, "R8");
    acc(32'h0700_0004, "R8");

    // R10: idle cycles after accesses
    step(1'b0, 8'h30, 32'h0, 1'b0, 32'h0, "R10");
    acc(32'h0500_0000, "R10");
    step(1'b0, 8'h30, 32'h0, 1'b0, 32'h0, "R10");

    // R11: same-cycle write and decode use the old values
    step(1'b1, 8'h30, {8'd4, 8'd0, 16'h0}, 1'b1, 32'h0100_0000, "R11");
    acc(32'h0100_0000, "R11");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      bit we;
      int u;
      logic [31:0] aa;
      we = ($urandom_range(0, 3) == 0);
      u = $urandom_range(0, 40);
      aa = (32'(u) << 23) | 32'($urandom_range(0, 32'h7F_FFFF));
      if ($urandom_range(0, 7) == 0) aa = $urandom;
      step(we, 8'h30 + 8'(4 * $urandom_range(0, 3)),
           {8'($urandom_range(0, 40)), 8'($urandom_range(0, 40)), 16'($urandom)},
           $urandom_range(0, 4) != 0, aa, "R7");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule